// File: doc/BRIEF.md
# Oversampled Serial Frame Decoder

This block recovers framed bytes from an asynchronous serial line that is sampled once per clock, with eight clock samples for each bit. The raw line is first brought into the clock domain by a two-stage register chain. A five-sample majority vote then removes short disturbances. A modulo-8 phase counter picks one sample in the middle of each bit, and a frame state machine consumes these picked bits.

A frame on the line has this form. The idle level is 1. A frame opens with a low start bit and a high frame-start bit. Each byte is preceded by a two-bit lead-in, high then low, and its eight data bits follow least significant first. After the last byte the frame closes with a low bit and then a high bit. The high-to-low edge inside every byte lead-in realigns the phase counter, so slow drift between the sender and the receiver never builds up over more than one byte.

The consumer sets how many bytes a frame carries. It receives each byte with a one-cycle valid pulse, one pulse when a frame completes, and one pulse when a fixed framing bit has the wrong value. After a framing error the machine goes back to idle.

Top module: `ovsd_frame_decoder`

## Requirements
- R1: After a synchronous active-high reset, `byte_valid`, `frame_done` and `fmt_err` are 0, and the decoder waits in idle for a start bit.
- R2: Each recovered bit is the majority of the last five synchronised samples. One or two wrong samples inside a bit, placed away from its middle, do not change the recovered byte.
- R3: The phase counter is loaded with 1 in any cycle where resync is active. Resync is active in idle while the previous voted bit is 1, and in the second lead-in state on a voted 1-to-0 edge. Otherwise the counter counts modulo 8, and a strobe occurs when it reads 4. Because of this, a byte whose high lead-in bit lasts 6 or 10 samples instead of 8 is still decoded correctly.
- R4: Data bits arrive least significant first. `byte_data` and a one-cycle `byte_valid` appear in the cycle after the strobe that takes the eighth data bit.
- R5: After each byte the machine starts another byte lead-in while fewer than `exp_bytes` bytes have been received. Otherwise it expects the closing low and high bits, and it pulses `frame_done` for one cycle after the closing high bit.
- R6: A frame-start bit sampled as 0 produces a one-cycle `fmt_err`. The decoder returns to idle without `frame_done`, and the next correct frame is decoded normally.
- R7: A closing low bit sampled as 1 produces `fmt_err` and no `frame_done`. The bytes already delivered in that frame remain valid.
- R8: A high line in idle, including dips of at most two samples, starts no frame and produces no output pulse.
- R9: An `exp_bytes` of 0 is treated like 1: the frame closes after its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, eight samples per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| exp_bytes | input | 8 | Number of bytes in each frame |
| byte_data | output | 8 | Last recovered byte |
| byte_valid | output | 1 | One-cycle pulse when `byte_data` is new |
| frame_done | output | 1 | One-cycle pulse after a complete frame |
| fmt_err | output | 1 | One-cycle pulse on a wrong framing bit |

## Verification
Two counter updates can fall in the same cycle: the lead-in edge resync and the counter's normal modulo-8 advance. When they coincide, the resync must win. The bench provokes this by making the high lead-in bit too short (6 samples) in one byte and too long (10 samples) in another. The edge then lands at a counter value other than 0, and the counter has to jump to 1 instead of advancing. The bench judges the result by whether every following data bit is still strobed in its middle, which shows in the scoreboard as the exact byte values and as a clean `frame_done` with no `fmt_err`.

// File: rtl/ovsd_pkg.sv
package ovsd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FSTRT = 3'd1,
    ST_LEAD0 = 3'd2,
    ST_LEAD1 = 3'd3,
    ST_DATA  = 3'd4,
    ST_END1  = 3'd5,
    ST_END0  = 3'd6
  } ovsd_state_t;
endpackage

// File: rtl/ovsd_sync.sv
module ovsd_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ovsd_voter.sv
module ovsd_voter #(
  parameter int LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic voted
);
  localparam int THR = (LEN + 1) / 2;
  localparam int CW  = $clog2(LEN + 1);

  logic [LEN-1:0] win;
  logic [CW-1:0]  ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < LEN; i++) ones = ones + CW'(win[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win   <= '1;
      voted <= 1'b1;
    end else begin
      win   <= {win[LEN-2:0], din};
      voted <= (ones >= CW'(THR));
    end
  end

  // R2: a window that is all ones gives a voted 1 next cycle
  a_r2_unanimous_high: assert property (@(posedge clk) disable iff (rst)
    (&win) |=> voted);
  // R2: a window that is all zeros gives a voted 0 next cycle
  a_r2_unanimous_low: assert property (@(posedge clk) disable iff (rst)
    (win == '0) |=> !voted);
endmodule

// File: rtl/ovsd_timer.sv
module ovsd_timer #(
  parameter int OVS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic resync,
  output logic strobe
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (resync)              cnt <= CW'(1);
    else if (cnt == CW'(OVS - 1)) cnt <= '0;
    else                          cnt <= cnt + CW'(1);
  end

  assign strobe = (cnt == CW'(MID));

  // R3: resync wins over the normal advance and loads 1
  a_r3_resync_loads_one: assert property (@(posedge clk) disable iff (rst)
    resync |=> (cnt == CW'(1)));
  // R3: without resync the counter steps by one modulo OVS
  a_r3_modulo_step: assert property (@(posedge clk) disable iff (rst)
    (!resync && cnt != CW'(OVS - 1)) |=> (cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/ovsd_fsm.sv
module ovsd_fsm
  import ovsd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              voted,
  input  logic              strobe,
  input  logic [CNT_W-1:0]  exp_bytes,
  output logic              resync,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_valid,
  output logic              frame_done,
  output logic              fmt_err
);
  localparam int IW = $clog2(BYTE_W);

  ovsd_state_t      st;
  logic             v_prev;
  logic [IW-1:0]    idx;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0] nbytes;
  logic [CNT_W:0]   next_cnt;
  logic [BYTE_W-1:0] next_byte;

  assign resync = ((st == ST_IDLE) && v_prev) ||
                  ((st == ST_LEAD1) && v_prev && !voted);
  assign next_cnt  = {1'b0, nbytes} + (CNT_W+1)'(1);
  assign next_byte = {voted, shreg[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      v_prev     <= 1'b1;
      idx        <= '0;
      shreg      <= '0;
      nbytes     <= '0;
      byte_data  <= '0;
      byte_valid <= 1'b0;
      frame_done <= 1'b0;
      fmt_err    <= 1'b0;
    end else begin
      v_prev     <= voted;
      byte_valid <= 1'b0;
      frame_done <= 1'b0;
      fmt_err    <= 1'b0;
      if (strobe) begin
        unique case (st)
          ST_IDLE: if (!voted) begin
            st     <= ST_FSTRT;
            nbytes <= '0;
          end
          ST_FSTRT: if (voted) st <= ST_LEAD0;
                    else begin fmt_err <= 1'b1; st <= ST_IDLE; end
          ST_LEAD0: if (voted) st <= ST_LEAD1;
                    else begin fmt_err <= 1'b1; st <= ST_IDLE; end
          ST_LEAD1: if (!voted) begin
            st  <= ST_DATA;
            idx <= '0;
          end else begin
            fmt_err <= 1'b1;
            st      <= ST_IDLE;
          end
          ST_DATA: begin
            shreg <= next_byte;
            if (idx == IW'(BYTE_W - 1)) begin
              byte_data  <= next_byte;
              byte_valid <= 1'b1;
              nbytes     <= nbytes + CNT_W'(1);
              if (next_cnt >= {1'b0, exp_bytes}) st <= ST_END1;
              else                               st <= ST_LEAD0;
            end else begin
              idx <= idx + IW'(1);
            end
          end
          ST_END1: if (!voted) st <= ST_END0;
                   else begin fmt_err <= 1'b1; st <= ST_IDLE; end
          ST_END0: begin
            st <= ST_IDLE;
            if (voted) frame_done <= 1'b1;
            else       fmt_err    <= 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R6: an error pulse is always accompanied by the idle state
  a_r6_err_returns_idle: assert property (@(posedge clk) disable iff (rst)
    fmt_err |-> (st == ST_IDLE));
  // R4: the byte valid pulse lasts a single cycle
  a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);
  // R5: the frame done pulse lasts a single cycle and ends in idle
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (st == ST_IDLE) ##1 !frame_done);
  // R5: at most one of the three result pulses per cycle
  a_r5_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({byte_valid, frame_done, fmt_err}));
  // R4: state only moves in strobe cycles
  a_r4_state_holds: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(st));
endmodule

// File: rtl/ovsd_frame_decoder.sv
module ovsd_frame_decoder #(
  parameter int OVS      = 8,
  parameter int VOTE_LEN = 5,
  parameter int SYNC_STG = 2,
  parameter int BYTE_W   = 8,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_in,
  input  logic [CNT_W-1:0]  exp_bytes,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_valid,
  output logic              frame_done,
  output logic              fmt_err
);
  logic rx_s, voted, resync, strobe;

  ovsd_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .din(rx_in), .dout(rx_s)
  );

  ovsd_voter #(.LEN(VOTE_LEN)) u_vote (
    .clk(clk), .rst(rst), .din(rx_s), .voted(voted)
  );

  ovsd_timer #(.OVS(OVS)) u_timer (
    .clk(clk), .rst(rst), .resync(resync), .strobe(strobe)
  );

  ovsd_fsm #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .voted(voted), .strobe(strobe),
    .exp_bytes(exp_bytes), .resync(resync), .byte_data(byte_data),
    .byte_valid(byte_valid), .frame_done(frame_done), .fmt_err(fmt_err)
  );
endmodule

// File: tb/ovsd_frame_decoder_test.sv
module ovsd_frame_decoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_in = 1'b1;
  logic [7:0] exp_bytes = 8'd1;
  logic [7:0] byte_data;
  logic       byte_valid, frame_done, fmt_err;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  int         evt_q[$];   // 1 = done, 2 = format error

  always #4 clk = ~clk;

  ovsd_frame_decoder uut (
    .clk(clk), .rst(rst), .rx_in(rx_in), .exp_bytes(exp_bytes),
    .byte_data(byte_data), .byte_valid(byte_valid),
    .frame_done(frame_done), .fmt_err(fmt_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // glitch: flips samples 1 and 2 of the bit when set
  task automatic send_bit(input logic val, input int len, input bit glitch);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_in = (glitch && (i == 1 || i == 2)) ? ~val : val;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_in = 1'b1;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int lead_len, input bit glitch,
                           input bit expect_it);
    send_bit(1'b1, lead_len, 1'b0);
    send_bit(1'b0, 8, 1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i], 8, glitch && i[0]);
    if (expect_it) exp_q.push_back(b);
  endtask

  task automatic frame_open();
    send_bit(1'b0, 8, 1'b0);
    send_bit(1'b1, 8, 1'b0);
  endtask

  task automatic frame_close(input logic end1);
    send_bit(end1, 8, 1'b0);
    if (end1) begin
      evt_q.push_back(2);
    end else begin
      send_bit(1'b1, 8, 1'b0);
      evt_q.push_back(1);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (byte_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected byte", byte_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(byte_data == e, "R4 byte value", byte_data, e);
        end
      end
      if (frame_done || fmt_err) begin
        int got;
        got = frame_done ? 1 : 2;
        if (evt_q.size() == 0) check(1'b0, "R8 unexpected event", got, 0);
        else begin
          int e;
          e = evt_q.pop_front();
          check(got == e, "R5 R6 R7 event kind", got, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(byte_valid == 1'b0, "R1 byte_valid after reset", byte_valid, 0);
    check(frame_done == 1'b0, "R1 frame_done after reset", frame_done, 0);
    check(fmt_err == 1'b0, "R1 fmt_err after reset", fmt_err, 0);
    rst = 1'b0;
    idle(24);

    // R4 R5: single byte frame
    exp_bytes = 8'd1;
    frame_open(); send_byte(8'hA5, 8, 1'b0, 1'b1); frame_close(1'b0); idle(32);

    // R2: three bytes with two-sample glitches in odd data bits
    exp_bytes = 8'd3;
    frame_open();
    send_byte(8'h3C, 8, 1'b1, 1'b1);
    send_byte(8'h00, 8, 1'b1, 1'b1);
    send_byte(8'hFF, 8, 1'b1, 1'b1);
    frame_close(1'b0); idle(32);

    // R3: short and long high lead-in bits force an off-phase resync
    exp_bytes = 8'd2;
    frame_open();
    send_byte(8'h81, 6, 1'b0, 1'b1);
    send_byte(8'h7E, 10, 1'b0, 1'b1);
    frame_close(1'b0); idle(32);

    // R9: zero byte count closes after one byte
    exp_bytes = 8'd0;
    frame_open(); send_byte(8'h5A, 8, 1'b0, 1'b1); frame_close(1'b0); idle(32);

    // R8: short dips in idle start nothing
    exp_bytes = 8'd1;
    for (int k = 0; k < 4; k++) begin
      send_bit(1'b0, 2, 1'b0);
      idle(12);
    end
    idle(40);
    check(exp_q.size() == 0 && evt_q.size() == 0, "R8 idle dips quiet",
          exp_q.size() + evt_q.size(), 0);

    // R6: bad frame-start bit
    send_bit(1'b0, 8, 1'b0);
    send_bit(1'b0, 8, 1'b0);
    evt_q.push_back(2);
    idle(40);

    // R7: bad closing bit after a good byte
    frame_open(); send_byte(8'h33, 8, 1'b0, 1'b1); frame_close(1'b1); idle(40);

    // R6: recovery after errors
    exp_bytes = 8'd2;
    frame_open();
    send_byte(8'hC3, 8, 1'b0, 1'b1);
    send_byte(8'h12, 8, 1'b0, 1'b1);
    frame_close(1'b0); idle(40);

    check(exp_q.size() == 0, "R4 R5 all bytes delivered", exp_q.size(), 0);
    check(evt_q.size() == 0, "R5 R6 R7 all events seen", evt_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule